// File: doc/BRIEF.md
# DMA Descriptor Fetch and Write-Back Unit

This unit looks after the transfer descriptors of a small two-channel DMA controller. Software programs two table base addresses and a set of channel enable bits through a simple register write port. When an enabled channel sees a trigger and holds no descriptor, the unit reads that channel's 128-bit first descriptor from the descriptor table in SRAM. The table is indexed by channel number, with each entry 16 bytes long.

Bit 0 of the lowest descriptor word is the valid flag. A valid descriptor is handed to the datapath with a one-cycle start strobe, and the channel becomes active. An invalid descriptor raises a one-cycle error strobe for that channel, and the channel returns to idle. While a channel is active, the datapath can ask for its descriptor to be stored into the write-back table. The unit writes the four words and then strobes a done flag for that channel.

The two tables may sit at different addresses or at the same address. Every SRAM access is a single 32-bit word. Only one descriptor move is in progress at any time, and the lower channel number wins when several channels are waiting.

Top module: `dma_desc_unit`

## Requirements
- R1: After reset, no SRAM request is made, no channel is active, and the start, error and done outputs are all low.
- R2: A config write with `cfg_sel`=0 sets the descriptor table base. A write with `cfg_sel`=1 sets the write-back table base. A write with `cfg_sel`=2 sets the channel enables, with bit n enabling channel n. Bits [3:0] of a base address are ignored, so the effective base is `cfg_wdata & ~32'hF`.
- R3: A trigger on an enabled, idle channel n causes four read accesses (`mem_we_o`=0). Their addresses are desc_base + 16n + 0, +4, +8 and +12, issued in that order.
- R4: If bit 0 of the word read from offset 0 is 1, `desc_start_o` pulses for one cycle. During that cycle `desc_ch_o`=n and `desc_o`={word3,word2,word1,word0}. Channel n then becomes active.
- R5: If that bit is 0, `err_o[n]` pulses for one cycle, `desc_start_o` stays low and channel n stays inactive.
- R6: A trigger causes no SRAM access when its channel is disabled, or when the channel already has a fetch waiting or in progress, or when the channel is active.
- R7: When several channels are waiting, the lowest channel number is served first. One descriptor move completes before the next one begins.
- R8: A write-back request on active channel n causes four writes at wb_base + 16n + 0, +4, +8 and +12, in that order. The data are the words of the descriptor that channel n holds, lowest word first. `wb_done_o[n]` then pulses for one cycle, and the channel stays active.
- R9: A write-back request on an inactive channel causes no SRAM access and no done pulse.
- R10: When both bases are equal, a write-back on channel n overwrites that channel's first descriptor entry with the held descriptor.
- R11: `ch_end_i[n]` makes channel n inactive, and a later trigger fetches the descriptor again.
- R12: `mem_req_o`, `mem_addr_o`, `mem_we_o` and `mem_wdata_o` hold steady until `mem_ack_i` arrives. Each acknowledge completes exactly one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Config register write strobe |
| cfg_sel | input | 2 | Register select: 0 descriptor base, 1 write-back base, 2 enables |
| cfg_wdata | input | 32 | Config write data |
| trig_i | input | NUM_CH | Per-channel transfer trigger |
| wb_req_i | input | NUM_CH | Per-channel write-back request |
| ch_end_i | input | NUM_CH | Per-channel end of transfer from the datapath |
| mem_req_o | output | 1 | SRAM word request |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_addr_o | output | 32 | SRAM byte address |
| mem_wdata_o | output | 32 | SRAM write data |
| mem_ack_i | input | 1 | SRAM acknowledge for the current word |
| mem_rdata_i | input | 32 | SRAM read data, valid with the acknowledge |
| desc_start_o | output | 1 | Valid descriptor handed to the datapath |
| desc_ch_o | output | CH_W | Channel of the descriptor being handed over |
| desc_o | output | 128 | Fetched descriptor |
| err_o | output | NUM_CH | Invalid descriptor strobe per channel |
| wb_done_o | output | NUM_CH | Write-back complete strobe per channel |
| active_o | output | NUM_CH | Channel holds a descriptor |

## Verification
The assertions assume that the SRAM acknowledges a word only while a request is pending. They also assume that `mem_rdata_i` is valid in the cycle of the acknowledge. The bench memory model meets these assumptions: it answers each request cycle after one cycle of latency and drops the acknowledge in the cycle that follows. Inputs change only at the falling clock edge. A trigger or request lasts one cycle, and the bench writes new base addresses only while the unit is idle. This means the assertions that a request holds steady and that addresses step upward never see a table move under a transfer in progress.

// File: rtl/dd_pkg.sv
package dd_pkg;

    localparam int WORD_W     = 32;
    localparam int DESC_WORDS = 4;
    localparam int DESC_W     = WORD_W * DESC_WORDS;
    localparam int WIDX_W     = $clog2(DESC_WORDS);
    localparam int BASE_HI_W  = WORD_W - 4;

    typedef enum logic {
        OP_FETCH = 1'b0,
        OP_WB    = 1'b1
    } op_e;

    typedef enum logic [1:0] {
        ES_IDLE = 2'd0,
        ES_XFER = 2'd1,
        ES_DONE = 2'd2
    } eng_state_e;

    typedef enum logic [1:0] {
        SEL_DESC_BASE = 2'd0,
        SEL_WB_BASE   = 2'd1,
        SEL_ENABLE    = 2'd2
    } cfg_sel_e;

    function automatic logic [WORD_W-1:0] entry_word_addr(
        input logic [BASE_HI_W-1:0] base_hi,
        input logic [BASE_HI_W-1:0] ch,
        input logic [WIDX_W-1:0]    widx
    );
        logic [BASE_HI_W-1:0] entry;
        entry = base_hi + ch;
        return {entry, widx, 2'b00};
    endfunction

endpackage

// File: rtl/dd_prio_arb.sv
module dd_prio_arb #(
    parameter int N   = 2,
    parameter int IDW = 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N-1:0]   req,
    output logic [N-1:0]   grant,
    output logic [IDW-1:0] gnt_idx,
    output logic           any
);

    always_comb begin
        gnt_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) gnt_idx = IDW'(i);
        end
    end

    assign any = |req;

    for (genvar g = 0; g < N; g++) begin : g_gnt
        assign grant[g] = req[g] && (gnt_idx == IDW'(g));
    end

    // R7: one winner at most, and only a requester can win
    a_r7_grant_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && ((grant & ~req) == '0));

    // R7: when any request is waiting, a winner is chosen
    a_r7_grant_present: assert property (@(posedge clk) disable iff (rst)
        any |-> (grant != '0));

endmodule

// File: rtl/dd_addr_gen.sv
module dd_addr_gen
    import dd_pkg::*;
#(
    parameter int CH_W = 1
) (
    input  logic [BASE_HI_W-1:0] base_hi,
    input  logic [CH_W-1:0]      ch,
    input  logic [WIDX_W-1:0]    widx,
    output logic [WORD_W-1:0]    addr
);

    assign addr = entry_word_addr(base_hi, BASE_HI_W'(ch), widx);

endmodule

// File: rtl/dd_xfer_engine.sv
module dd_xfer_engine
    import dd_pkg::*;
#(
    parameter int CH_W = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [CH_W-1:0]      start_ch,
    input  op_e                  start_op,
    input  logic [BASE_HI_W-1:0] desc_base_hi,
    input  logic [BASE_HI_W-1:0] wb_base_hi,
    input  logic [DESC_W-1:0]    wb_words,
    input  logic                 mem_ack,
    input  logic [WORD_W-1:0]    mem_rdata,
    output logic                 busy,
    output logic                 done,
    output logic [CH_W-1:0]      cur_ch,
    output op_e                  cur_op,
    output logic [DESC_W-1:0]    rd_words,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [WORD_W-1:0]    mem_addr,
    output logic [WORD_W-1:0]    mem_wdata
);

    eng_state_e           state_q;
    logic [WIDX_W-1:0]    widx_q;
    logic [CH_W-1:0]      ch_q;
    op_e                  op_q;
    logic [BASE_HI_W-1:0] sel_base;

    assign busy    = (state_q != ES_IDLE);
    assign done    = (state_q == ES_DONE);
    assign cur_ch  = ch_q;
    assign cur_op  = op_q;
    assign mem_req = (state_q == ES_XFER);
    assign mem_we  = (op_q == OP_WB);

    assign sel_base  = (op_q == OP_WB) ? wb_base_hi : desc_base_hi;
    assign mem_wdata = wb_words[widx_q*WORD_W +: WORD_W];

    dd_addr_gen #(.CH_W(CH_W)) u_addr (
        .base_hi (sel_base),
        .ch      (ch_q),
        .widx    (widx_q),
        .addr    (mem_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ES_IDLE;
            widx_q   <= '0;
            ch_q     <= '0;
            op_q     <= OP_FETCH;
            rd_words <= '0;
        end else begin
            unique case (state_q)
                ES_IDLE: begin
                    if (start) begin
                        state_q <= ES_XFER;
                        widx_q  <= '0;
                        ch_q    <= start_ch;
                        op_q    <= start_op;
                    end
                end
                ES_XFER: begin
                    if (mem_ack) begin
                        if (op_q == OP_FETCH) begin
                            rd_words[widx_q*WORD_W +: WORD_W] <= mem_rdata;
                        end
                        if (widx_q == WIDX_W'(DESC_WORDS - 1)) begin
                            state_q <= ES_DONE;
                        end else begin
                            widx_q <= widx_q + 1'b1;
                        end
                    end
                end
                ES_DONE: state_q <= ES_IDLE;
                default: state_q <= ES_IDLE;
            endcase
        end
    end

    // R12: an unanswered request keeps its address, direction and data
    a_r12_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_wdata)));

    // R3: the next word of a move sits 4 bytes above the previous one
    a_r3_ascending: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && (widx_q != WIDX_W'(DESC_WORDS - 1)))
            |=> (mem_req && (mem_addr == $past(mem_addr) + 32'd4)));

    // R7: a new move is only launched when the engine is free
    a_r7_single_move: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

endmodule

// File: rtl/dma_desc_unit.sv
module dma_desc_unit
    import dd_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic [NUM_CH-1:0] trig_i,
    input  logic [NUM_CH-1:0] wb_req_i,
    input  logic [NUM_CH-1:0] ch_end_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [31:0]       mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [31:0]       mem_rdata_i,
    output logic              desc_start_o,
    output logic [CH_W-1:0]   desc_ch_o,
    output logic [127:0]      desc_o,
    output logic [NUM_CH-1:0] err_o,
    output logic [NUM_CH-1:0] wb_done_o,
    output logic [NUM_CH-1:0] active_o
);

    logic [BASE_HI_W-1:0] desc_base_hi_q;
    logic [BASE_HI_W-1:0] wb_base_hi_q;
    logic [NUM_CH-1:0]    en_q;

    logic [NUM_CH-1:0]    pend_fetch_q;
    logic [NUM_CH-1:0]    pend_wb_q;
    logic [NUM_CH-1:0]    active_q;
    logic [DESC_W-1:0]    desc_q [NUM_CH];

    logic [NUM_CH-1:0]    arb_req;
    logic [NUM_CH-1:0]    arb_grant;
    logic [CH_W-1:0]      arb_idx;
    logic                 arb_any;

    logic                 eng_start;
    op_e                  eng_start_op;
    logic                 eng_busy;
    logic                 eng_done;
    logic [CH_W-1:0]      eng_ch;
    op_e                  eng_op;
    logic [DESC_W-1:0]    eng_rd;

    logic                 fetch_ok;
    logic                 fetch_bad;
    logic                 wb_fin;

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            desc_base_hi_q <= '0;
            wb_base_hi_q   <= '0;
            en_q           <= '0;
        end else if (cfg_we) begin
            unique case (cfg_sel_e'(cfg_sel))
                SEL_DESC_BASE: desc_base_hi_q <= cfg_wdata[31:4];
                SEL_WB_BASE:   wb_base_hi_q   <= cfg_wdata[31:4];
                SEL_ENABLE:    en_q           <= cfg_wdata[NUM_CH-1:0];
                default: ;
            endcase
        end
    end

    // arbitration among waiting channels
    assign arb_req = pend_fetch_q | pend_wb_q;

    dd_prio_arb #(.N(NUM_CH), .IDW(CH_W)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (arb_req),
        .grant   (arb_grant),
        .gnt_idx (arb_idx),
        .any     (arb_any)
    );

    assign eng_start    = arb_any && !eng_busy;
    assign eng_start_op = pend_wb_q[arb_idx] ? OP_WB : OP_FETCH;

    dd_xfer_engine #(.CH_W(CH_W)) u_eng (
        .clk          (clk),
        .rst          (rst),
        .start        (eng_start),
        .start_ch     (arb_idx),
        .start_op     (eng_start_op),
        .desc_base_hi (desc_base_hi_q),
        .wb_base_hi   (wb_base_hi_q),
        .wb_words     (desc_q[eng_ch]),
        .mem_ack      (mem_ack_i),
        .mem_rdata    (mem_rdata_i),
        .busy         (eng_busy),
        .done         (eng_done),
        .cur_ch       (eng_ch),
        .cur_op       (eng_op),
        .rd_words     (eng_rd),
        .mem_req      (mem_req_o),
        .mem_we       (mem_we_o),
        .mem_addr     (mem_addr_o),
        .mem_wdata    (mem_wdata_o)
    );

    assign fetch_ok  = eng_done && (eng_op == OP_FETCH) && eng_rd[0];
    assign fetch_bad = eng_done && (eng_op == OP_FETCH) && !eng_rd[0];
    assign wb_fin    = eng_done && (eng_op == OP_WB);

    // per-channel state
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_fetch_q <= '0;
            pend_wb_q    <= '0;
            active_q     <= '0;
            for (int c = 0; c < NUM_CH; c++) desc_q[c] <= '0;
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                logic cur;
                cur = eng_busy && (eng_ch == CH_W'(c));
                if (eng_start && arb_grant[c]) begin
                    pend_fetch_q[c] <= 1'b0;
                    pend_wb_q[c]    <= 1'b0;
                end else begin
                    if (trig_i[c] && en_q[c] && !pend_fetch_q[c] && !active_q[c]
                        && !(cur && eng_op == OP_FETCH)) begin
                        pend_fetch_q[c] <= 1'b1;
                    end
                    if (ch_end_i[c]) begin
                        pend_wb_q[c] <= 1'b0;
                    end else if (wb_req_i[c] && active_q[c]
                                 && !(cur && eng_op == OP_WB)) begin
                        pend_wb_q[c] <= 1'b1;
                    end
                end
                if (ch_end_i[c]) begin
                    active_q[c] <= 1'b0;
                end else if (fetch_ok && eng_ch == CH_W'(c)) begin
                    active_q[c] <= 1'b1;
                end
                if (fetch_ok && eng_ch == CH_W'(c)) begin
                    desc_q[c] <= eng_rd;
                end
            end
        end
    end

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            err_o[c]     = fetch_bad && (eng_ch == CH_W'(c));
            wb_done_o[c] = wb_fin && (eng_ch == CH_W'(c));
        end
    end

    assign desc_start_o = fetch_ok;
    assign desc_ch_o    = eng_ch;
    assign desc_o       = eng_rd;
    assign active_o     = active_q;

    // R8: write-back completions come one at a time
    a_r8_done_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wb_done_o));

    // R4: a handed-over descriptor makes its channel active next cycle
    a_r4_start_activates: assert property (@(posedge clk) disable iff (rst)
        (desc_start_o && !ch_end_i[desc_ch_o]) |=> active_o[$past(desc_ch_o)]);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R5: an invalid descriptor leaves its channel inactive
        a_r5_err_idle: assert property (@(posedge clk) disable iff (rst)
            err_o[g] |=> !active_o[g]);

        // R6: a channel is never handed a descriptor while already active
        a_r6_no_restart: assert property (@(posedge clk) disable iff (rst)
            (desc_start_o && desc_ch_o == CH_W'(g)) |-> !active_o[g]);
    end

endmodule

// File: tb/dma_desc_unit_tb_top.sv
module dma_desc_unit_tb_top;

    localparam int NCH = 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cfg_we = 1'b0;
    logic [1:0]     cfg_sel = '0;
    logic [31:0]    cfg_wdata = '0;
    logic [NCH-1:0] trig = '0;
    logic [NCH-1:0] wb_req = '0;
    logic [NCH-1:0] ch_end = '0;
    logic           mem_req, mem_we;
    logic [31:0]    mem_addr, mem_wdata;
    logic           mem_ack = 1'b0;
    logic [31:0]    mem_rdata = '0;
    logic           desc_start;
    logic [0:0]     desc_ch;
    logic [127:0]   desc;
    logic [NCH-1:0] err, wb_done, active;

    always #10 clk = ~clk;  // 50 MHz

    dma_desc_unit #(.NUM_CH(NCH)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .trig_i(trig), .wb_req_i(wb_req), .ch_end_i(ch_end),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
        .desc_start_o(desc_start), .desc_ch_o(desc_ch), .desc_o(desc),
        .err_o(err), .wb_done_o(wb_done), .active_o(active)
    );

    int checks = 0;
    int errors = 0;

    // SRAM model: one-cycle latency, ack dropped between words
    logic [31:0] sram [64];
    int          acc_cnt = 0;
    logic [31:0] acc_addr [32];
    logic        acc_we [32];

    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) sram[mem_addr[7:2]] <= mem_wdata;
            mem_rdata <= sram[mem_addr[7:2]];
            if (acc_cnt < 32) begin
                acc_addr[acc_cnt] = mem_addr;
                acc_we[acc_cnt]   = mem_we;
            end
            acc_cnt = acc_cnt + 1;
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // output monitor
    int           n_start = 0;
    int           start_ch_log [8];
    logic [127:0] last_desc = '0;
    int           n_err [NCH];
    int           n_done [NCH];

    initial for (int c = 0; c < NCH; c++) begin n_err[c] = 0; n_done[c] = 0; end

    always @(negedge clk) begin
        if (!rst) begin
            if (desc_start) begin
                if (n_start < 8) start_ch_log[n_start] = int'(desc_ch);
                last_desc = desc;
                n_start = n_start + 1;
            end
            for (int c = 0; c < NCH; c++) begin
                if (err[c])     n_err[c]  = n_err[c] + 1;
                if (wb_done[c]) n_done[c] = n_done[c] + 1;
            end
        end
    end

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual cycles %0d expected below 100000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_trig(input logic [NCH-1:0] v);
        @(negedge clk); trig = v;
        @(negedge clk); trig = '0;
    endtask

    task automatic pulse_wb(input logic [NCH-1:0] v);
        @(negedge clk); wb_req = v;
        @(negedge clk); wb_req = '0;
    endtask

    task automatic pulse_end(input logic [NCH-1:0] v);
        @(negedge clk); ch_end = v;
        @(negedge clk); ch_end = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic put_desc(input int byte_addr, input logic [127:0] d);
        for (int w = 0; w < 4; w++) sram[(byte_addr >> 2) + w] = d[w*32 +: 32];
    endtask

    function automatic logic [127:0] get_desc(input int byte_addr);
        logic [127:0] d;
        for (int w = 0; w < 4; w++) d[w*32 +: 32] = sram[(byte_addr >> 2) + w];
        return d;
    endfunction

    localparam logic [127:0] DESC_A = 128'h3333_3333_2222_2222_1111_1111_A5A5_0001;
    localparam logic [127:0] DESC_B = 128'h7777_7777_6666_6666_5555_5555_B0B0_0003;

    task automatic check_reads(input string req, input int first, input int base);
        for (int i = 0; i < 4; i++) begin
            check(req, {96'd0, acc_addr[first+i]}, 128'(base + 4*i));
            check(req, {127'd0, acc_we[first+i]}, 128'd0);
        end
    endtask

    task automatic t_reset;
        check("R1 mem_req", {127'd0, mem_req}, 0);
        check("R1 active", {126'd0, active}, 0);
        check("R1 strobes", {124'd0, desc_start, err, wb_done[0]}, 0);
    endtask

    task automatic t_config;
        // R2: low nibble of base ignored
        cfg_write(2'd0, 32'h0000_004B);
        cfg_write(2'd1, 32'h0000_0080);
        cfg_write(2'd2, 32'h0000_0003);
    endtask

    task automatic t_fetch_ch0;
        int s0;
        s0 = n_start; acc_cnt = 0;
        pulse_trig(2'b01);
        idle(20);
        check("R4 start count", 128'(n_start - s0), 128'd1);
        check("R4 desc ch", 128'(start_ch_log[s0]), 128'd0);
        check("R4 desc data", last_desc, DESC_A);
        check("R4 active", {126'd0, active}, 128'd1);
        check("R3 count", 128'(acc_cnt), 128'd4);
        check_reads("R2 R3 read order", 0, 32'h40);
    endtask

    task automatic t_retrig_active;
        acc_cnt = 0;
        pulse_trig(2'b01);
        idle(15);
        check("R6 retrigger while active", 128'(acc_cnt), 128'd0);
    endtask

    task automatic t_writeback;
        int d0;
        d0 = n_done[0]; acc_cnt = 0;
        pulse_wb(2'b01);
        idle(20);
        check("R8 done pulse", 128'(n_done[0] - d0), 128'd1);
        check("R8 wb data", get_desc(32'h80), DESC_A);
        for (int i = 0; i < 4; i++) begin
            check("R8 wb addr", {96'd0, acc_addr[i]}, 128'(32'h80 + 4*i));
            check("R8 wb write", {127'd0, acc_we[i]}, 128'd1);
        end
        check("R8 still active", {126'd0, active}, 128'd1);
    endtask

    task automatic t_wb_inactive;
        int d1;
        d1 = n_done[1]; acc_cnt = 0;
        pulse_wb(2'b10);
        idle(15);
        check("R9 no access", 128'(acc_cnt), 128'd0);
        check("R9 no done", 128'(n_done[1] - d1), 128'd0);
    endtask

    task automatic t_priority;
        int s0;
        pulse_end(2'b11);
        check("R11 ended", {126'd0, active}, 128'd0);
        s0 = n_start; acc_cnt = 0;
        pulse_trig(2'b11);
        idle(40);
        check("R7 two starts", 128'(n_start - s0), 128'd2);
        check("R7 first ch0", 128'(start_ch_log[s0]), 128'd0);
        check("R7 second ch1", 128'(start_ch_log[s0+1]), 128'd1);
        check_reads("R7 ch0 reads first", 0, 32'h40);
        check_reads("R3 ch1 entry", 4, 32'h50);
        check("R11 refetched", {126'd0, active}, 128'd3);
    endtask

    task automatic t_invalid;
        int e1, s0;
        pulse_end(2'b11);
        put_desc(32'h50, DESC_B & ~128'd1);
        e1 = n_err[1]; s0 = n_start;
        pulse_trig(2'b10);
        idle(20);
        check("R5 err pulse", 128'(n_err[1] - e1), 128'd1);
        check("R5 no start", 128'(n_start - s0), 128'd0);
        check("R5 inactive", {126'd0, active}, 128'd0);
        put_desc(32'h50, DESC_B);
    endtask

    task automatic t_disabled;
        cfg_write(2'd2, 32'h0000_0001);
        acc_cnt = 0;
        pulse_trig(2'b10);
        idle(15);
        check("R6 disabled trigger", 128'(acc_cnt), 128'd0);
        check("R6 disabled inactive", {126'd0, active}, 128'd0);
    endtask

    task automatic t_alias;
        int d1;
        cfg_write(2'd1, 32'h0000_0040);
        cfg_write(2'd2, 32'h0000_0003);
        pulse_trig(2'b10);
        idle(20);
        check("R10 fetched", last_desc, DESC_B);
        sram[32'h50 >> 2] = 32'hDEAD_BEEF;
        d1 = n_done[1]; acc_cnt = 0;
        pulse_wb(2'b10);
        idle(20);
        check("R10 done", 128'(n_done[1] - d1), 128'd1);
        check("R10 entry restored", get_desc(32'h50), DESC_B);
        check("R10 first addr", {96'd0, acc_addr[0]}, 128'(32'h50));
    endtask

    initial begin
        for (int i = 0; i < 64; i++) sram[i] = 32'h0;
        put_desc(32'h40, DESC_A);
        put_desc(32'h50, DESC_B);
        idle(3);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_config();
        t_fetch_ch0();
        t_retrig_active();
        t_writeback();
        t_wb_inactive();
        t_priority();
        t_invalid();
        t_disabled();
        t_alias();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule